// File: doc/BRIEF.md
# Pixel Colour Component Extractor

This block sits between a display controller's pixel fetch path and its output stage. It takes one raw framebuffer word per cycle and produces 8-bit red, green and blue values. Each colour has a select word that fixes three things: the lowest bit of the field to pull out of the pixel, how many bits that field has, and a fallback colour value. A format word states how many bytes of the incoming word belong to the pixel. Bytes above that count are cleared before any extraction.

A field shorter than eight bits is placed at the top of the output byte, and its own upper bits are repeated to fill the low bits, so full scale maps to 0xFF. A field longer than eight bits keeps only its most significant eight bits. The fallback value replaces the extracted value in three cases: the length is zero, the pixel lies outside the visible area, or the fetch path reports an underrun. If software gives only one colour a fallback of 0xFF, underruns show up on screen in that colour. The result is registered, and the valid and active flags are carried through the same register stage.

Top module: `pix_comp_extract`

## Requirements
- R1: While `rst` is high at a rising edge, every output is zero after that edge.
- R2: Outputs follow inputs with exactly one cycle of latency: `vld_out` and `act_out` equal `pix_vld` and `act_in` from the previous edge, and the colour outputs are computed from that edge's inputs.
- R3: A select word has the fallback colour in bits [23:16], the field length in bits [11:8] and the lowest bit index in bits [4:0]. With length 8, the output is pixel bits [idx+7:idx].
- R4: With a length L from 1 to 7, the L-bit field occupies output bits [7:8-L]. Each lower output bit n takes the field bit that sits L positions above it in the output. For example, 5-bit 10000 gives 0x84.
- R5: With a length L from 9 to 15, the output is the top eight bits of the L-bit field, which are pixel bits [idx+L-1:idx+L-8].
- R6: A length of 0 outputs the component's fallback value, with no regard to the pixel.
- R7: When `act_in` is low, all three components output their fallback values.
- R8: When `urun_in` is high, all three components output their fallback values, even when `act_in` is high.
- R9: Format word bits [4:3] hold bytes-per-pixel minus one (0 means one byte). Pixel bits at or above 8×bytes-per-pixel read as zero.
- R10: Field bits that lie above pixel bit 31 read as zero.
- R11: Each component uses only its own select word, so the three components can have different positions, lengths and fallbacks at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fmt | input | 32 | Format word; bits [4:3] hold bytes-per-pixel minus one |
| cfg_sel_r | input | 32 | Red select word |
| cfg_sel_g | input | 32 | Green select word |
| cfg_sel_b | input | 32 | Blue select word |
| pix_in | input | 32 | Raw framebuffer pixel word |
| pix_vld | input | 1 | Pixel word is valid |
| act_in | input | 1 | Pixel lies in the visible area |
| urun_in | input | 1 | Fetch buffer underrun |
| r_out | output | 8 | Registered red value |
| g_out | output | 8 | Registered green value |
| b_out | output | 8 | Registered blue value |
| vld_out | output | 1 | Valid flag, delayed to line up with the colour outputs |
| act_out | output | 1 | Active flag, delayed to line up with the colour outputs |

## Verification
The only state in this block is the single output register stage. A fault in it, or in the combinational path that feeds it, shows up in the very next cycle as a wrong colour byte or a wrong flag. The bench's model therefore compares every output on every clock. A masking error appears only for pixel words whose upper bytes are non-zero, so those words are driven on purpose. A replication error appears only for fields shorter than eight bits whose value is not all-zero or all-one, and such values are driven as well. A priority error among the fallback conditions appears only when the field length is non-zero, so the fallback tests use non-zero lengths.

// File: rtl/pce_pkg.sv
package pce_pkg;
  localparam int CFG_W    = 32;
  localparam int COMP_W   = 8;
  localparam int LEN_W    = 4;
  localparam int IDX_W    = 5;
  localparam int DFLT_LSB = 16;
  localparam int LEN_LSB  = 8;
  localparam int IDX_LSB  = 0;
  localparam int FMT_LSB  = 3;
  localparam int BPP_W    = 2;
  localparam int N_COMP   = 3;

  typedef struct packed {
    logic [COMP_W-1:0] dflt;
    logic [LEN_W-1:0]  len;
    logic [IDX_W-1:0]  idx;
  } comp_sel_t;

  function automatic comp_sel_t unpack_sel(input logic [CFG_W-1:0] w);
    comp_sel_t s;
    s.dflt = w[DFLT_LSB +: COMP_W];
    s.len  = w[LEN_LSB  +: LEN_W];
    s.idx  = w[IDX_LSB  +: IDX_W];
    return s;
  endfunction
endpackage

// File: rtl/pce_byte_mask.sv
module pce_byte_mask #(
  parameter int PIX_W = 32,
  parameter int BPP_W = 2
) (
  input  logic [PIX_W-1:0] pix,
  input  logic [BPP_W-1:0] bpp_m1,
  output logic [PIX_W-1:0] pix_masked
);
  localparam int N_LANES = PIX_W / 8;

  genvar ln;
  generate
    for (ln = 0; ln < N_LANES; ln++) begin : g_lane
      if (ln == 0) begin : g_first
        assign pix_masked[7:0] = pix[7:0];
      end else begin : g_upper
        logic keep;
        assign keep = (int'(bpp_m1) >= ln);
        assign pix_masked[ln*8 +: 8] = keep ? pix[ln*8 +: 8] : 8'h00;
      end
    end
  endgenerate
endmodule

// File: rtl/pce_field_extract.sv
module pce_field_extract #(
  parameter int PIX_W  = 32,
  parameter int LEN_W  = 4,
  parameter int IDX_W  = 5,
  parameter int COMP_W = 8
) (
  input  logic [PIX_W-1:0]  pix,
  input  logic [LEN_W-1:0]  len,
  input  logic [IDX_W-1:0]  idx,
  output logic [COMP_W-1:0] value
);
  localparam int FLD_W = (1 << LEN_W) - 1;

  logic [PIX_W-1:0] shifted;
  logic [FLD_W:0]   fmask;
  logic [FLD_W-1:0] field;
  logic [COMP_W-1:0] narrow_v;
  logic [COMP_W-1:0] wide_v;
  logic [FLD_W-1:0]  wide_sh;

  assign shifted = pix >> idx;
  assign fmask   = ({{FLD_W{1'b0}}, 1'b1} << len) - 1'b1;
  assign field   = shifted[FLD_W-1:0] & fmask[FLD_W-1:0];

  assign wide_sh = field >> (len - LEN_W'(COMP_W));
  assign wide_v  = wide_sh[COMP_W-1:0];

  always_comb begin
    logic [LEN_W-1:0] k;
    narrow_v = '0;
    k = len - 1'b1;
    if (len != '0) begin
      for (int i = COMP_W - 1; i >= 0; i--) begin
        narrow_v[i] = field[k];
        if (k == '0) k = len - 1'b1;
        else         k = k - 1'b1;
      end
    end
  end

  assign value = (int'(len) >= COMP_W) ? wide_v : narrow_v;
endmodule

// File: rtl/pix_comp_extract.sv
module pix_comp_extract
  import pce_pkg::*;
#(
  parameter int PIX_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CFG_W-1:0]  cfg_fmt,
  input  logic [CFG_W-1:0]  cfg_sel_r,
  input  logic [CFG_W-1:0]  cfg_sel_g,
  input  logic [CFG_W-1:0]  cfg_sel_b,
  input  logic [PIX_W-1:0]  pix_in,
  input  logic              pix_vld,
  input  logic              act_in,
  input  logic              urun_in,
  output logic [COMP_W-1:0] r_out,
  output logic [COMP_W-1:0] g_out,
  output logic [COMP_W-1:0] b_out,
  output logic              vld_out,
  output logic              act_out
);
  logic [PIX_W-1:0]  pix_m;
  logic [BPP_W-1:0]  bpp_m1;
  logic              force_dflt;
  comp_sel_t         sel   [N_COMP];
  logic [COMP_W-1:0] ext_v [N_COMP];
  logic [COMP_W-1:0] nxt_v [N_COMP];
  logic [COMP_W-1:0] comp_q[N_COMP];

  assign bpp_m1     = cfg_fmt[FMT_LSB +: BPP_W];
  assign force_dflt = urun_in | ~act_in;

  assign sel[0] = unpack_sel(cfg_sel_r);
  assign sel[1] = unpack_sel(cfg_sel_g);
  assign sel[2] = unpack_sel(cfg_sel_b);

  pce_byte_mask #(.PIX_W(PIX_W), .BPP_W(BPP_W)) u_mask (
    .pix        (pix_in),
    .bpp_m1     (bpp_m1),
    .pix_masked (pix_m)
  );

  genvar c;
  generate
    for (c = 0; c < N_COMP; c++) begin : g_comp
      pce_field_extract #(
        .PIX_W(PIX_W), .LEN_W(LEN_W), .IDX_W(IDX_W), .COMP_W(COMP_W)
      ) u_ext (
        .pix   (pix_m),
        .len   (sel[c].len),
        .idx   (sel[c].idx),
        .value (ext_v[c])
      );

      assign nxt_v[c] = (force_dflt || sel[c].len == '0) ? sel[c].dflt : ext_v[c];

      always_ff @(posedge clk) begin
        if (rst) comp_q[c] <= '0;
        else     comp_q[c] <= nxt_v[c];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_out <= 1'b0;
      act_out <= 1'b0;
    end else begin
      vld_out <= pix_vld;
      act_out <= act_in;
    end
  end

  assign r_out = comp_q[0];
  assign g_out = comp_q[1];
  assign b_out = comp_q[2];

  // Reference slice for the byte-wide green field, taken straight from the port.
  logic [PIX_W-1:0] chk_g_sh;
  assign chk_g_sh = pix_in >> cfg_sel_g[IDX_LSB +: IDX_W];

  p_vld_set_r2: assert property (@(posedge clk) disable iff (rst)
    pix_vld |=> vld_out);
  p_vld_clr_r2: assert property (@(posedge clk) disable iff (rst)
    !pix_vld |=> !vld_out);
  p_act_set_r2: assert property (@(posedge clk) disable iff (rst)
    act_in |=> act_out);
  p_len8_r3: assert property (@(posedge clk) disable iff (rst)
    (act_in && !urun_in && cfg_sel_g[LEN_LSB +: LEN_W] == LEN_W'(8)
     && cfg_fmt[FMT_LSB +: BPP_W] == '1)
    |=> g_out == $past(chk_g_sh[COMP_W-1:0]));
  p_inact_dflt_r7: assert property (@(posedge clk) disable iff (rst)
    !act_in |=> (r_out == $past(cfg_sel_r[DFLT_LSB +: COMP_W])
             && g_out == $past(cfg_sel_g[DFLT_LSB +: COMP_W])
             && b_out == $past(cfg_sel_b[DFLT_LSB +: COMP_W])));
  p_urun_dflt_r8: assert property (@(posedge clk) disable iff (rst)
    urun_in |=> (r_out == $past(cfg_sel_r[DFLT_LSB +: COMP_W])
             && g_out == $past(cfg_sel_g[DFLT_LSB +: COMP_W])
             && b_out == $past(cfg_sel_b[DFLT_LSB +: COMP_W])));
endmodule

// File: tb/pix_comp_extract_tb.sv
`timescale 1ns/1ps
module pix_comp_extract_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] cfg_fmt, cfg_sel_r, cfg_sel_g, cfg_sel_b, pix_in;
  logic        pix_vld, act_in, urun_in;
  logic [7:0]  r_out, g_out, b_out;
  logic        vld_out, act_out;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pix_comp_extract u_dut (
    .clk(clk), .rst(rst), .cfg_fmt(cfg_fmt),
    .cfg_sel_r(cfg_sel_r), .cfg_sel_g(cfg_sel_g), .cfg_sel_b(cfg_sel_b),
    .pix_in(pix_in), .pix_vld(pix_vld), .act_in(act_in), .urun_in(urun_in),
    .r_out(r_out), .g_out(g_out), .b_out(b_out),
    .vld_out(vld_out), .act_out(act_out)
  );

  function automatic logic [31:0] mk_sel(int dflt, int len, int idx);
    return (32'(dflt & 255) << 16) | (32'(len & 15) << 8) | 32'(idx & 31);
  endfunction

  function automatic logic [31:0] mk_fmt(int bytes);
    return 32'(bytes - 1) << 3;
  endfunction

  // Behavioural model of one component.
  function automatic logic [7:0] model_comp(logic [31:0] pix, logic [31:0] sel,
                                            logic [31:0] fmt, logic act, logic ur);
    longint unsigned p, f;
    int len, idx, bytes, pos;
    logic [7:0] res;
    len   = int'(sel[11:8]);
    idx   = int'(sel[4:0]);
    bytes = int'(fmt[4:3]) + 1;
    if (!act || ur || len == 0) return sel[23:16];
    p = longint'(pix) & ((64'd1 << (8 * bytes)) - 1);
    f = (p >> idx) & ((64'd1 << len) - 1);
    if (len >= 8) return 8'(f >> (len - 8));
    res = '0;
    for (int i = 0; i < 8; i++) begin
      pos = len - 1 - (i % len);
      res[7 - i] = 1'((f >> pos) & 1);
    end
    return res;
  endfunction

  task automatic step(string tag);
    logic [7:0] er, eg, eb;
    logic ev, ea;
    if (rst) begin
      er = 0; eg = 0; eb = 0; ev = 0; ea = 0;
    end else begin
      er = model_comp(pix_in, cfg_sel_r, cfg_fmt, act_in, urun_in);
      eg = model_comp(pix_in, cfg_sel_g, cfg_fmt, act_in, urun_in);
      eb = model_comp(pix_in, cfg_sel_b, cfg_fmt, act_in, urun_in);
      ev = pix_vld; ea = act_in;
    end
    @(posedge clk);
    @(negedge clk);
    n_run++;
    if (r_out !== er || g_out !== eg || b_out !== eb || vld_out !== ev || act_out !== ea) begin
      n_fail++;
      $display("FAIL %s: got rgb=%h%h%h v=%b a=%b expected rgb=%h%h%h v=%b a=%b",
               tag, r_out, g_out, b_out, vld_out, act_out, er, eg, eb, ev, ea);
    end
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1; pix_vld = 1; act_in = 1; urun_in = 0;
    cfg_fmt = mk_fmt(4); pix_in = 32'hFFFF_FFFF;
    cfg_sel_r = mk_sel(8'h11, 8, 16); cfg_sel_g = mk_sel(8'h22, 8, 8);
    cfg_sel_b = mk_sel(8'h33, 8, 0);
    step("R1 reset"); step("R1 reset");
    rst = 0;

    // R3 / R11: byte fields at three positions
    pix_in = 32'h00AA_BBCC; step("R3 R11 bytes");
    pix_in = 32'h1234_5678; step("R3 R11 bytes");
    pix_vld = 0; pix_in = 32'h00F0_0F55; step("R2 vld low");
    pix_vld = 1; step("R2 vld high");

    // R4: 5-6-5 layout in two bytes
    cfg_fmt = mk_fmt(2);
    cfg_sel_r = mk_sel(0, 5, 11); cfg_sel_g = mk_sel(0, 6, 5); cfg_sel_b = mk_sel(0, 5, 0);
    pix_in = 32'h0000_8410; step("R4 565 half");
    pix_in = 32'h0000_F81F; step("R4 565 full");
    pix_in = 32'h0000_5AA5; step("R4 565 mixed");
    cfg_sel_r = mk_sel(0, 1, 3); cfg_sel_g = mk_sel(0, 3, 0); cfg_sel_b = mk_sel(0, 7, 1);
    pix_in = 32'h0000_00AD; step("R4 short lengths");

    // R5: wide fields
    cfg_fmt = mk_fmt(4);
    cfg_sel_r = mk_sel(0, 12, 4); cfg_sel_g = mk_sel(0, 15, 0); cfg_sel_b = mk_sel(0, 9, 20);
    pix_in = 32'h9ABC_DEF1; step("R5 wide");
    pix_in = 32'h5A5A_3C3C; step("R5 wide");

    // R6: zero length uses fallback
    cfg_sel_r = mk_sel(8'h7E, 0, 0); cfg_sel_g = mk_sel(8'h81, 8, 0); cfg_sel_b = mk_sel(8'hC3, 0, 9);
    pix_in = 32'hFFFF_FFFF; step("R6 zero len");

    // R7: inactive area
    cfg_sel_r = mk_sel(8'h10, 8, 0); cfg_sel_g = mk_sel(8'h20, 8, 8); cfg_sel_b = mk_sel(8'h30, 4, 16);
    act_in = 0; pix_in = 32'hDEAD_BEEF; step("R7 inactive");
    step("R2 R7 inactive hold");
    act_in = 1; step("R2 active return");

    // R8: underrun overrides active, red-only fallback
    cfg_sel_r = mk_sel(8'hFF, 8, 0); cfg_sel_g = mk_sel(0, 8, 8); cfg_sel_b = mk_sel(0, 8, 16);
    urun_in = 1; step("R8 underrun");
    act_in = 0; step("R8 underrun inactive");
    urun_in = 0; act_in = 1; step("R8 underrun end");

    // R9: byte masking
    cfg_sel_r = mk_sel(0, 8, 8); cfg_sel_g = mk_sel(0, 8, 0); cfg_sel_b = mk_sel(0, 8, 24);
    pix_in = 32'hFFFF_FF12;
    for (int nb = 1; nb <= 4; nb++) begin
      cfg_fmt = mk_fmt(nb); step("R9 bytes per pixel");
    end
    cfg_fmt = mk_fmt(3); cfg_sel_r = mk_sel(0, 12, 14); pix_in = 32'hFFFF_FFFF;
    step("R9 field across mask");

    // R10: field beyond top bit
    cfg_fmt = mk_fmt(4);
    cfg_sel_r = mk_sel(0, 8, 28); cfg_sel_g = mk_sel(0, 4, 30); cfg_sel_b = mk_sel(0, 15, 31);
    pix_in = 32'hB000_0000; step("R10 top bits");
    pix_in = 32'hFFFF_FFFF; step("R10 top bits");

    // R2/R11 mixed sweep
    for (int i = 0; i < 300; i++) begin
      cfg_fmt   = $urandom;
      cfg_sel_r = $urandom; cfg_sel_g = $urandom; cfg_sel_b = $urandom;
      pix_in    = $urandom;
      pix_vld   = 1'($urandom); act_in = ($urandom % 4) != 0; urun_in = ($urandom % 8) == 0;
      step("R2 R11 sweep");
    end

    rst = 1; step("R1 reset again");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule